// File: doc/BRIEF.md
# MSI-X Interrupt Vector Engine

This block keeps a table of message-signalled interrupt vectors and an array of pending bits beside it. Application logic raises a one-cycle request on the line of a vector. The block records the request as pending. While the vector is masked, the request stays pending. Once the vector is unmasked, the block builds a memory write request from that vector's message address and data and hands it to a transmit request interface. The transmit side holds one request at a time. It carries a flag that tells the packet builder whether the write needs a long header, which is the case when the upper address word is non-zero.

Host software reaches the block through a simple register port. It uses this port to program each vector's address, data and mask bit, and to read the pending bits. A constant output reports the table size as the entry count minus one. Software can therefore size the table without any configuration-space logic. A global function mask input defers every vector at once. Vectors that were deferred are sent automatically when their mask is lifted. Competing vectors are served lowest index first.

Top module: `msix_vec_engine`

## Requirements
- R1: After reset, tx_valid is low, every pending bit is 0, every vector's mask bit is 1, and its address and data fields are 0.
- R2: table_size always equals NUM_VEC-1 (11 bits wide, so 2047 stands for the largest table of 2048 vectors).
- R3: When reg_addr's top bit is 0, the access targets the table. The vector index is reg_addr[AW-2:4] and the field is reg_addr[3:2]: 0 is the lower address, 1 the upper address, 2 the message data and 3 vector control. Bit 0 of vector control is the mask bit and bits 31:1 read as 0. Bits 1:0 of the lower address are stored and read as 0. Address bits 1:0 are ignored. reg_rdata holds the addressed value from the cycle after reg_rd is sampled.
- R4: When reg_addr's top bit is 1, a read returns pending dword k = reg_addr[AW-2:2]. Bit i of that dword is the pending bit of vector 32k+i. Writes to this region change nothing.
- R5: A request to a vector whose mask bit is 1 sets its pending bit and produces no write.
- R6: A request to an unmasked vector, sampled at edge k while the transmit stage is free and no lower vector is eligible, raises tx_valid after edge k+1. tx_addr is then {upper address, lower address} and tx_data is the message data.
- R7: tx_hdr4 is 1 exactly when the upper address word of the sent vector is non-zero, which selects a four-dword header. Otherwise it is 0, which selects a three-dword header with tx_addr[63:32] zero.
- R8: While tx_valid is high and tx_ready is low, tx_valid, tx_addr, tx_data and tx_hdr4 hold. A vector's pending bit clears on the edge that loads its write. A new write may load on the edge that accepts the previous one.
- R9: When several vectors are eligible, the one with the lowest index is sent first.
- R10: Clearing the mask bit of a pending vector causes that vector's write to be sent, and its pending bit then reads 0.
- R11: Further requests to a vector whose pending bit is already set produce one write, not one per request.
- R12: While func_mask is 1, no write is loaded and requests only set pending bits. The deferred vectors are sent after func_mask returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_mask | input | 1 | Global mask that defers all vectors |
| irq_req | input | NUM_VEC | One request strobe per vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | $clog2(NUM_VEC)+5 | Byte offset; top bit selects the pending array |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| table_size | output | 11 | Entry count minus one |
| tx_valid | output | 1 | Memory write request valid |
| tx_ready | input | 1 | Transmit side accepts the request |
| tx_addr | output | 64 | Write address |
| tx_data | output | 32 | Write payload dword |
| tx_hdr4 | output | 1 | 1 selects a four-dword header |

## Verification
The bench first sends a single request to an unmasked vector. This measures the two-edge latency and shows whether the upper address word selects the long header or the short one. It then sends several requests in one cycle while the transmit side stalls. This separates a correct lowest-index order and stable held fields from an arbiter that skips or reorders vectors. Requests to masked vectors, and repeated requests to one masked vector, show whether a request is held or dropped, and whether it is sent once or several times when the mask is lifted. Requests made under the function mask show that the global mask defers vectors rather than discarding them.

// File: rtl/msix_vec_pkg.sv
package msix_vec_pkg;

  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_CTRL    = 2'd3
  } vec_field_e;

  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] data;
    logic        masked;
  } vec_entry_t;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic        hdr4;
  } wr_req_t;

  // a non-zero upper word needs the long (four-dword) header
  function automatic logic wants_4dw(input logic [31:0] hi);
    return (hi != 32'd0);
  endfunction

  function automatic logic [31:0] dword_aligned(input logic [31:0] lo);
    return {lo[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] ctrl_word(input logic masked);
    return {31'd0, masked};
  endfunction

  function automatic logic [31:0] field_of(input vec_entry_t e, input vec_field_e f);
    logic [31:0] r;
    case (f)
      FLD_ADDR_LO: r = e.addr_lo;
      FLD_ADDR_HI: r = e.addr_hi;
      FLD_DATA:    r = e.data;
      default:     r = ctrl_word(e.masked);
    endcase
    return r;
  endfunction

  function automatic wr_req_t make_req(input vec_entry_t e);
    wr_req_t r;
    r.addr = {e.addr_hi, dword_aligned(e.addr_lo)};
    r.data = e.data;
    r.hdr4 = wants_4dw(e.addr_hi);
    return r;
  endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_vec_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned AW      = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_VEC-1:0] pend,
  input  logic [IDX_W-1:0]   lk_idx,
  output vec_entry_t         lk_entry,
  output logic [NUM_VEC-1:0] mask_vec
);
  localparam int unsigned TBL_AW    = AW - 1;
  localparam int unsigned PBA_WORDS = (NUM_VEC + 31) / 32;
  localparam int unsigned WSEL_W    = TBL_AW - 2;

  vec_entry_t ent_arr [NUM_VEC];

  logic             wr_tbl;
  logic [IDX_W-1:0] wr_idx;
  vec_field_e       wr_fld;
  assign wr_tbl = wr_en && !wr_addr[AW-1];
  assign wr_idx = wr_addr[TBL_AW-1:4];
  assign wr_fld = vec_field_e'(wr_addr[3:2]);

  // byte lanes inside a dword carry no meaning on this port
  logic unused_lsb;
  assign unused_lsb = ^{wr_addr[1:0], rd_addr[1:0]};

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    vec_entry_t ent_q;
    logic       hit;
    assign hit = wr_tbl && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '{addr_lo: '0, addr_hi: '0, data: '0, masked: 1'b1};
      end else if (hit) begin
        case (wr_fld)
          FLD_ADDR_LO: ent_q.addr_lo <= dword_aligned(wr_data);
          FLD_ADDR_HI: ent_q.addr_hi <= wr_data;
          FLD_DATA:    ent_q.data    <= wr_data;
          default:     ent_q.masked  <= wr_data[0];
        endcase
      end
    end

    assign ent_arr[g]  = ent_q;
    assign mask_vec[g] = ent_q.masked;
  end

  // lookup for the arbiter's winner
  always_comb begin
    lk_entry = ent_arr[0];
    for (int e = 1; e < NUM_VEC; e++) begin
      if (lk_idx == IDX_W'(e)) lk_entry = ent_arr[e];
    end
  end

  // register read path
  logic [PBA_WORDS*32-1:0] pend_pad;
  logic [IDX_W-1:0]        rd_idx;
  logic [WSEL_W-1:0]       rd_word;
  logic [31:0]             rd_mux;
  assign pend_pad = (PBA_WORDS*32)'(pend);
  assign rd_idx   = rd_addr[TBL_AW-1:4];
  assign rd_word  = rd_addr[TBL_AW-1:2];

  always_comb begin
    rd_mux = '0;
    if (rd_addr[AW-1]) begin
      for (int w = 0; w < PBA_WORDS; w++) begin
        if (rd_word == WSEL_W'(w)) rd_mux = pend_pad[w*32 +: 32];
      end
    end else begin
      for (int e = 0; e < NUM_VEC; e++) begin
        if (rd_idx == IDX_W'(e)) rd_mux = field_of(ent_arr[e], vec_field_e'(rd_addr[3:2]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R4: the pending region is never a write target
  a_r4_pba_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr[AW-1] |=> $stable(mask_vec));

endmodule

// File: rtl/msix_pend_arb.sv
module msix_pend_arb #(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned IDX_W   = 3
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req,
  input  logic [NUM_VEC-1:0] mask_vec,
  input  logic               func_mask,
  input  logic               slot_free,
  output logic [NUM_VEC-1:0] pend,
  output logic               grant_vld,
  output logic [IDX_W-1:0]   grant_idx
);
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] eligible;
  logic [NUM_VEC-1:0] grant_oh;
  logic [NUM_VEC-1:0] clr;

  assign eligible = func_mask ? '0 : (pend_q & ~mask_vec);
  // isolate lowest set bit: ascending service order
  assign grant_oh = eligible & (~eligible + NUM_VEC'(1));
  assign grant_vld = slot_free && (|eligible);
  assign clr       = grant_vld ? grant_oh : '0;

  always_comb begin
    grant_idx = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (eligible[v]) grant_idx = IDX_W'(v);
    end
  end

  // a request arriving with the issue re-arms the bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | req;
  end

  assign pend = pend_q;

  // R8: the bit of a vector just loaded is clear unless re-requested
  a_r8_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && !req[grant_idx] |=> !pend_q[$past(grant_idx)]);

  // R11: a request always leaves its bit set
  a_r11_req_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> (|pend_q));

endmodule

// File: rtl/msix_tx_stage.sv
module msix_tx_stage
  import msix_vec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  wr_req_t req_in,
  input  logic    tx_ready,
  output logic    tx_valid,
  output wr_req_t held,
  output logic    slot_free
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      held     <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      held     <= req_in;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  assign slot_free = !tx_valid || tx_ready;

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(held));

  a_r7_hdr_match: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (held.hdr4 == (held.addr[63:32] != 32'd0)));

  a_r3_dword_align: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (held.addr[1:0] == 2'b00));

endmodule

// File: rtl/msix_vec_engine.sv
module msix_vec_engine
  import msix_vec_pkg::*;
#(
  parameter  int unsigned NUM_VEC = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_VEC),
  localparam int unsigned AW      = IDX_W + 5
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               func_mask,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [10:0]        table_size,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [63:0]        tx_addr,
  output logic [31:0]        tx_data,
  output logic               tx_hdr4
);
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] mask_vec;
  logic               grant_vld;
  logic [IDX_W-1:0]   grant_idx;
  logic               slot_free;
  vec_entry_t         lk_entry;
  wr_req_t            next_req;
  wr_req_t            held;

  assign table_size = 11'(NUM_VEC - 1);

  msix_vec_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .AW(AW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .rd_en    (reg_rd),
    .rd_addr  (reg_addr),
    .rd_data  (reg_rdata),
    .pend     (pend),
    .lk_idx   (grant_idx),
    .lk_entry (lk_entry),
    .mask_vec (mask_vec)
  );

  msix_pend_arb #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (irq_req),
    .mask_vec  (mask_vec),
    .func_mask (func_mask),
    .slot_free (slot_free),
    .pend      (pend),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx)
  );

  assign next_req = make_req(lk_entry);

  logic unused_mask_bit;
  assign unused_mask_bit = lk_entry.masked;

  msix_tx_stage u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (grant_vld),
    .req_in    (next_req),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .held      (held),
    .slot_free (slot_free)
  );

  assign tx_addr = held.addr;
  assign tx_data = held.data;
  assign tx_hdr4 = held.hdr4;

  // R5 and R12: a masked vector is never the one loaded
  a_r5_masked_never_sent: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> !mask_vec[grant_idx] && !func_mask);

  a_r12_fmask_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    func_mask && !tx_valid |=> !tx_valid);

endmodule

// File: tb/msix_vec_engine_tb.sv
module msix_vec_engine_tb;
  localparam int NV  = 8;
  localparam int AWB = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            func_mask = 1'b0;
  logic [NV-1:0]   irq_req = '0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [AWB-1:0]  reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [10:0]     table_size;
  logic            tx_valid;
  logic            tx_ready = 1'b0;
  logic [63:0]     tx_addr;
  logic [31:0]     tx_data;
  logic            tx_hdr4;

  always #2 clk = ~clk;

  msix_vec_engine #(.NUM_VEC(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .func_mask(func_mask), .irq_req(irq_req),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .table_size(table_size), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_data(tx_data), .tx_hdr4(tx_hdr4)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_lo [NV];
  logic [31:0] m_hi [NV];
  logic [31:0] m_dat [NV];
  bit          m_mask [NV];
  bit          m_pend [NV];
  bit          m_txv, m_tx4, m_rdv;
  logic [63:0] m_txa;
  logic [31:0] m_txd, m_rd;
  logic [31:0] seen_q [$];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r;
    int idx;
    r = '0;
    if (a[7]) begin
      if (a[6:2] == 5'd0)
        for (int v = 0; v < NV; v++) r[v] = m_pend[v];
    end else begin
      idx = int'(a[6:4]);
      case (a[3:2])
        2'd0: r = m_lo[idx];
        2'd1: r = m_hi[idx];
        2'd2: r = m_dat[idx];
        default: r = {31'd0, m_mask[idx]};
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin
        m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0; m_mask[v] = 1'b1; m_pend[v] = 1'b0;
      end
      m_txv = 1'b0; m_rdv = 1'b0; m_rd = '0; m_txa = '0; m_txd = '0; m_tx4 = 1'b0;
    end else begin
      bit free;
      int win;
      int idx;
      if (tx_valid && tx_ready) seen_q.push_back(tx_data);
      m_rdv = reg_rd;
      if (reg_rd) m_rd = m_read(reg_addr);
      free = !m_txv || tx_ready;
      if (m_txv && tx_ready) m_txv = 1'b0;
      win = -1;
      if (free && !func_mask)
        for (int v = NV - 1; v >= 0; v--) if (m_pend[v] && !m_mask[v]) win = v;
      if (win >= 0) begin
        m_txv = 1'b1;
        m_txa = {m_hi[win], m_lo[win]};
        m_txd = m_dat[win];
        m_tx4 = (m_hi[win] != 0);
        m_pend[win] = 1'b0;
      end
      if (reg_wr && !reg_addr[7]) begin
        idx = int'(reg_addr[6:4]);
        case (reg_addr[3:2])
          2'd0: m_lo[idx] = reg_wdata & 32'hFFFF_FFFC;
          2'd1: m_hi[idx] = reg_wdata;
          2'd2: m_dat[idx] = reg_wdata;
          default: m_mask[idx] = reg_wdata[0];
        endcase
      end
      for (int v = 0; v < NV; v++) if (irq_req[v]) m_pend[v] = 1'b1;
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 model tx_valid", 64'(tx_valid), 64'(m_txv));
      if (m_txv) begin
        chk("R6 model tx_addr", tx_addr, m_txa);
        chk("R6 model tx_data", 64'(tx_data), 64'(m_txd));
        chk("R7 model tx_hdr4", 64'(tx_hdr4), 64'(m_tx4));
      end
      if (m_rdv) chk("R3 model reg_rdata", 64'(reg_rdata), 64'(m_rd));
    end
  end

  // ---------------- stimulus helpers (called at negedge) ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NV-1:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  function automatic int count_of(input logic [31:0] v);
    int c = 0;
    foreach (seen_q[i]) if (seen_q[i] == v) c++;
    return c;
  endfunction

  localparam logic [7:0] PBA = 8'h80;

  initial begin
    logic [31:0] d;
    int base;
    int c6;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 / R2: reset state
    chk("R1 tx_valid after reset", 64'(tx_valid), 64'd0);
    chk("R2 table_size", 64'(table_size), 64'd7);
    for (int v = 0; v < NV; v++) begin
      rd(8'(v*16 + 12), d);
      chk("R1 mask bit set after reset", 64'(d), 64'd1);
    end
    rd(8'h00, d);
    chk("R1 lower address zero after reset", 64'(d), 64'd0);
    rd(PBA, d);
    chk("R1 pending array empty after reset", 64'(d), 64'd0);

    // R3: program the table and read fields back
    for (int v = 0; v < NV; v++) begin
      wr(8'(v*16 + 0), 32'hFEE0_0000 + 32'(v*16) + 32'd3);
      wr(8'(v*16 + 4), (v % 2 == 1) ? 32'h0001_0000 + 32'(v) : 32'd0);
      wr(8'(v*16 + 8), 32'h0000_A000 + 32'(v));
    end
    rd(8'h20, d);
    chk("R3 lower address low bits read zero", 64'(d), 64'hFEE0_0020);
    rd(8'h34, d);
    chk("R3 upper address field", 64'(d), 64'h0001_0003);
    rd(8'h59, d);
    chk("R3 data field ignoring byte bits", 64'(d), 64'h0000_A005);

    // R5: request to a masked vector is only held
    tx_ready = 1'b1;
    pulse(8'h04);
    tick(4);
    chk("R5 masked request sends nothing", 64'(seen_q.size()), 64'd0);
    rd(PBA, d);
    chk("R5 masked request pending", 64'(d), 64'h04);

    // R4: writing the pending array has no effect
    wr(PBA, 32'h0);
    wr(PBA, 32'hFF);
    rd(PBA, d);
    chk("R4 pending array write ignored", 64'(d), 64'h04);

    // R10: unmask the pending vector
    wr(8'h2C, 32'd0);
    tick(5);
    chk("R10 unmasked pending vector sent once", 64'(count_of(32'hA002)), 64'd1);
    rd(PBA, d);
    chk("R10 pending bit cleared", 64'(d), 64'd0);

    // R6 / R7: latency and header choice
    wr(8'h3C, 32'd0);
    wr(8'h4C, 32'd0);
    pulse(8'h10);
    chk("R6 no write one edge after request", 64'(tx_valid), 64'd0);
    tick(1);
    chk("R6 write valid after second edge", 64'(tx_valid), 64'd1);
    chk("R6 short address", tx_addr, 64'h0000_0000_FEE0_0040);
    chk("R6 data", 64'(tx_data), 64'h0000_A004);
    chk("R7 zero upper word gives 3dw", 64'(tx_hdr4), 64'd0);
    tick(3);
    pulse(8'h08);
    tick(1);
    chk("R6 long address", tx_addr, 64'h0001_0003_FEE0_0030);
    chk("R7 nonzero upper word gives 4dw", 64'(tx_hdr4), 64'd1);
    tick(3);

    // R8 / R9: stall with several eligible vectors
    wr(8'h5C, 32'd0);
    wr(8'h6C, 32'd0);
    tx_ready = 1'b0;
    base = seen_q.size();
    pulse(8'h78);
    tick(1);
    chk("R9 lowest vector first", 64'(tx_data), 64'h0000_A003);
    rd(PBA, d);
    chk("R8 pending cleared on load", 64'(d), 64'h70);
    chk("R8 valid held under stall", 64'(tx_valid), 64'd1);
    tick(2);
    chk("R8 data held under stall", 64'(tx_data), 64'h0000_A003);
    tx_ready = 1'b1;
    tick(8);
    chk("R9 count after release", 64'(seen_q.size() - base), 64'd4);
    if (seen_q.size() - base == 4) begin
      chk("R9 order 0", 64'(seen_q[base+0]), 64'h0000_A003);
      chk("R9 order 1", 64'(seen_q[base+1]), 64'h0000_A004);
      chk("R9 order 2", 64'(seen_q[base+2]), 64'h0000_A005);
      chk("R9 order 3", 64'(seen_q[base+3]), 64'h0000_A006);
    end

    // R11: repeated requests while pending
    wr(8'h6C, 32'd1);
    c6 = count_of(32'hA006);
    pulse(8'h40);
    tick(1);
    pulse(8'h40);
    rd(PBA, d);
    chk("R11 pending once", 64'(d), 64'h40);
    wr(8'h6C, 32'd0);
    tick(6);
    chk("R11 single write for repeated requests", 64'(count_of(32'hA006)), 64'(c6 + 1));

    // R12: function mask defers everything
    func_mask = 1'b1;
    base = seen_q.size();
    pulse(8'h10);
    tick(4);
    chk("R12 no write under function mask", 64'(seen_q.size() - base), 64'd0);
    rd(PBA, d);
    chk("R12 request held pending", 64'(d), 64'h10);
    func_mask = 1'b0;
    tick(5);
    chk("R12 deferred write sent", 64'(seen_q.size() - base), 64'd1);
    if (seen_q.size() > base)
      chk("R12 deferred write data", 64'(seen_q[base]), 64'h0000_A004);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule